// File: doc/BRIEF.md
# Flash Sector Lock Register Unit

This unit holds the program/erase protection bits for the sectors of a flash controller's low and mid address spaces. It keeps two independent lock registers, a primary and a secondary. The lock that the flash sequencer sees for each sector is the OR of that sector's bit in both registers. A bit at 1 protects its sector from program and erase. A bit at 0 lets the sector receive program and erase pulses.

Software reaches both registers through a simple register bus. The bus has an address, a write strobe, write data and registered read data. Writes take effect only when three things hold: the lock-enable input is high, no high-voltage operation is suspended, and no program/erase interlock is outstanding. The interlock is a sticky internal flag. The first array data write of an operation sets it, and the operation-done status clears it.

While reset is held, every implemented bit is loaded from a nonvolatile shadow input. An erased shadow (all ones) leaves every sector locked. A parameter mask names the sectors that physically exist. Bits of absent sectors are held at 1 in storage, on reads and on the lock output.

Top module: `flash_lock_regs`

## Requirements
- R1: `sect_lock[i]` is 1 exactly when sector i is locked in the primary register or in the secondary register. Sectors 0 to 5 map to low-field bits 0 to 5, and sectors 6 and 7 map to mid-field bits 0 and 1.
- R2: Address 0 selects the primary register and address 1 selects the secondary register. In each register word, bits 15:0 hold the low field and bits 17:16 hold the mid field, and all other bits read 0. A read of address 2 or 3 returns 0, and a write to either address changes nothing.
- R3: Low-field bits 15:6 always read 1, and writes to them are ignored.
- R4: An accepted write updates the register on the clock edge that samples it. Read data appears one cycle after the address is presented and shows the register as it was at that edge. Lock outputs change only after an accepted write.
- R5: A data write to the array (`arr_wr`) sets the interlock flag, and `op_done` clears it. Register writes are blocked while the flag is set. A write is also blocked in the cycle that sets the flag and in the cycle that `op_done` clears it. When `arr_wr` and `op_done` are high in the same cycle, the flag ends up set.
- R6: Register writes are ignored while `hv_susp` is high.
- R7: Register writes are ignored while `lock_en` is low.
- R8: While `rst_n` is low, each implemented bit loads from `shadow_pri` and `shadow_sec`, indexed by sector. An all-ones shadow leaves every sector locked.
- R9: A sector whose bit in `SECT_PRESENT` is 0 resets to 1 in both registers whatever the shadow holds. It ignores writes and always shows as locked on `sect_lock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset that loads the shadow values |
| reg_addr | input | ADDR_W | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| lock_en | input | 1 | Lock-register write enable |
| arr_wr | input | 1 | Program/erase data write to the array |
| op_done | input | 1 | Program/erase operation complete |
| hv_susp | input | 1 | High-voltage operation suspended |
| shadow_pri | input | NSECT | Reset value of the primary register, one bit per sector |
| shadow_sec | input | NSECT | Reset value of the secondary register, one bit per sector |
| sect_lock | output | NSECT | Final lock per sector |

## Verification
The bench builds the unit with `SECT_PRESENT = 8'h5F`, so sector 5 of the low field and sector 7 of the mid field are absent. With one missing sector in each field, the forced-one handling is visible on reads, on writes and on the OR output in both field positions. It also shows that shadow values and written values cannot unlock those sectors. The default field sizes keep the padding bits 15:6 in the word, so every read also checks that they stay at 1.

// File: rtl/flk_pkg.sv
package flk_pkg;
    localparam int unsigned ADDR_PRI = 0;
    localparam int unsigned ADDR_SEC = 1;

    typedef struct packed {
        logic busy;
    } ilk_state_t;
endpackage

// File: rtl/flk_interlock.sv
module flk_interlock
    import flk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arr_wr,
    input  logic op_done,
    output logic busy_o
);
    ilk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arr_wr)
            st_d.busy = 1'b1;
        else if (op_done)
            st_d.busy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign busy_o = st_q.busy;

    assert_ilk_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr |=> busy_o)
        else $error("interlock not set after array write");

    assert_ilk_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !arr_wr) |=> !busy_o)
        else $error("interlock not cleared after done");
endmodule

// File: rtl/flk_lock_bank.sv
module flk_lock_bank #(
    parameter int unsigned NSECT = 8,
    parameter logic [NSECT-1:0] PRESENT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSECT-1:0] shadow,
    input  logic             wr_en,
    input  logic [NSECT-1:0] wr_bits,
    output logic [NSECT-1:0] bits_o
);
    localparam logic [NSECT-1:0] ABSENT = ~PRESENT;

    typedef struct packed {
        logic [NSECT-1:0] bits;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en)
            st_d.bits = wr_bits | ABSENT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q.bits <= shadow | ABSENT;
        else
            st_q <= st_d;
    end

    assign bits_o = st_q.bits;

    assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bits_o))
        else $error("lock bank changed without write");
endmodule

// File: rtl/flk_lock_combine.sv
module flk_lock_combine #(
    parameter int unsigned NSECT = 8,
    parameter logic [NSECT-1:0] PRESENT = '1
) (
    input  logic [NSECT-1:0] pri_i,
    input  logic [NSECT-1:0] sec_i,
    output logic [NSECT-1:0] lock_o
);
    for (genvar g = 0; g < NSECT; g++) begin : g_sect
        assign lock_o[g] = PRESENT[g] ? (pri_i[g] | sec_i[g]) : 1'b1;
    end

    always_comb begin
        assert_absent_locked_R9: assert (&(lock_o | PRESENT))
            else $error("absent sector shown unlocked");
    end
endmodule

// File: rtl/flash_lock_regs.sv
module flash_lock_regs
    import flk_pkg::*;
#(
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned LOW_FIELD_W = 16,
    parameter int unsigned LOW_SECT    = 6,
    parameter int unsigned MID_SECT    = 2,
    parameter int unsigned MID_LSB     = 16,
    parameter logic [LOW_SECT+MID_SECT-1:0] SECT_PRESENT = '1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic                         reg_wr,
    input  logic [DATA_W-1:0]            reg_wdata,
    output logic [DATA_W-1:0]            reg_rdata,
    input  logic                         lock_en,
    input  logic                         arr_wr,
    input  logic                         op_done,
    input  logic                         hv_susp,
    input  logic [LOW_SECT+MID_SECT-1:0] shadow_pri,
    input  logic [LOW_SECT+MID_SECT-1:0] shadow_sec,
    output logic [LOW_SECT+MID_SECT-1:0] sect_lock
);
    localparam int unsigned NSECT = LOW_SECT + MID_SECT;
    localparam logic [ADDR_W-1:0] A_PRI = ADDR_W'(ADDR_PRI);
    localparam logic [ADDR_W-1:0] A_SEC = ADDR_W'(ADDR_SEC);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    logic             ilk_busy;
    logic             wr_ok;
    logic             pri_we;
    logic             sec_we;
    logic [NSECT-1:0] wr_bits;
    logic [NSECT-1:0] pri_bits;
    logic [NSECT-1:0] sec_bits;
    logic             wdata_unused;

    function automatic logic [DATA_W-1:0] pack_word(input logic [NSECT-1:0] b);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int i = 0; i < LOW_SECT; i++)
            w[i] = b[i];
        for (int i = LOW_SECT; i < LOW_FIELD_W; i++)
            w[i] = 1'b1;
        for (int j = 0; j < MID_SECT; j++)
            w[MID_LSB+j] = b[LOW_SECT+j];
        return w;
    endfunction

    // sector-ordered write vector from the two fields of the bus word
    for (genvar g = 0; g < LOW_SECT; g++) begin : g_low
        assign wr_bits[g] = reg_wdata[g];
    end
    for (genvar g = 0; g < MID_SECT; g++) begin : g_mid
        assign wr_bits[LOW_SECT+g] = reg_wdata[MID_LSB+g];
    end
    assign wdata_unused = ^reg_wdata;

    flk_interlock u_ilk (
        .clk     (clk),
        .rst_n   (rst_n),
        .arr_wr  (arr_wr),
        .op_done (op_done),
        .busy_o  (ilk_busy)
    );

    assign wr_ok  = reg_wr && lock_en && !hv_susp && !ilk_busy && !arr_wr;
    assign pri_we = wr_ok && (reg_addr == A_PRI);
    assign sec_we = wr_ok && (reg_addr == A_SEC);

    flk_lock_bank #(.NSECT(NSECT), .PRESENT(SECT_PRESENT)) u_pri (
        .clk     (clk),
        .rst_n   (rst_n),
        .shadow  (shadow_pri),
        .wr_en   (pri_we),
        .wr_bits (wr_bits),
        .bits_o  (pri_bits)
    );

    flk_lock_bank #(.NSECT(NSECT), .PRESENT(SECT_PRESENT)) u_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .shadow  (shadow_sec),
        .wr_en   (sec_we),
        .wr_bits (wr_bits),
        .bits_o  (sec_bits)
    );

    flk_lock_combine #(.NSECT(NSECT), .PRESENT(SECT_PRESENT)) u_comb (
        .pri_i  (pri_bits),
        .sec_i  (sec_bits),
        .lock_o (sect_lock)
    );

    always_comb begin
        rd_d = rd_q;
        if (reg_addr == A_PRI)
            rd_d.rdata = pack_word(pri_bits);
        else if (reg_addr == A_SEC)
            rd_d.rdata = pack_word(sec_bits);
        else
            rd_d.rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else
            rd_q <= rd_d;
    end

    assign reg_rdata = rd_q.rdata;

    assert_busy_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && ilk_busy) |=> ($stable(pri_bits) && $stable(sec_bits)))
        else $error("write accepted during interlock");

    assert_susp_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hv_susp) |=> ($stable(pri_bits) && $stable(sec_bits)))
        else $error("write accepted while suspended");

    assert_enable_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !lock_en) |=> ($stable(pri_bits) && $stable(sec_bits)))
        else $error("write accepted with lock enable low");

    assert_lock_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pri_we && !sec_we) |=> $stable(sect_lock))
        else $error("lock output moved without write");

    assert_pad_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr == A_PRI) || (reg_addr == A_SEC)) |=> (&reg_rdata[LOW_FIELD_W-1:LOW_SECT]))
        else $error("padding bits not read as one");
endmodule

// File: tb/test_flash_lock_regs.sv
`timescale 1ns/1ps
module test_flash_lock_regs;
    localparam logic [7:0] PRES = 8'h5F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lock_en = 1'b0;
    logic        arr_wr = 1'b0;
    logic        op_done = 1'b0;
    logic        hv_susp = 1'b0;
    logic [7:0]  shadow_pri = '1;
    logic [7:0]  shadow_sec = '1;
    logic [7:0]  sect_lock;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_pri, exp_sec;

    always #2.5 clk = ~clk;

    flash_lock_regs #(.SECT_PRESENT(PRES)) i_flash_lock_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lock_en(lock_en),
        .arr_wr(arr_wr), .op_done(op_done), .hv_susp(hv_susp),
        .shadow_pri(shadow_pri), .shadow_sec(shadow_sec), .sect_lock(sect_lock)
    );

    // word layout: low field 15:0 (sectors 0..5, pad 15:6 = 1), mid field 17:16
    function automatic logic [31:0] word_of(input logic [7:0] b);
        return {14'b0, b[7:6], 10'h3FF, b[5:0]};
    endfunction

    function automatic logic [7:0] bits_of(input logic [31:0] w);
        return {w[17:16], w[5:0]} | ~PRES;
    endfunction

    function automatic logic [31:0] flip_word(input logic [7:0] b);
        return {14'b0, ~b[7:6], 10'b0, ~b[5:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] p, input logic [7:0] s);
        @(negedge clk);
        rst_n = 1'b0; shadow_pri = p; shadow_sec = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_pri = p | ~PRES;
        exp_sec = s | ~PRES;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit take);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (take && a == 2'd0) exp_pri = bits_of(d);
        if (take && a == 2'd1) exp_sec = bits_of(d);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(2'd0, v);
        chk({tag, " primary word"}, v, word_of(exp_pri));
        rd(2'd1, v);
        chk({tag, " secondary word"}, v, word_of(exp_sec));
        chk({tag, " lock output"}, {24'b0, sect_lock}, {24'b0, exp_pri | exp_sec});
    endtask

    task automatic t_reset_load;
        do_reset(8'hA5, 8'h0F);
        check_all("R8 shadow load");
        chk("R9 absent sectors after reset", {30'b0, sect_lock[7], sect_lock[5]}, 32'd3);
    endtask

    task automatic t_write_or;
        lock_en = 1'b1;
        wr(2'd0, 32'h0, 1'b1);
        check_all("R4 primary write");
        wr(2'd1, 32'h0, 1'b1);
        chk("R1 all implemented unlocked", {24'b0, sect_lock}, {24'b0, ~PRES});
        wr(2'd1, 32'h0001_0002, 1'b1);
        check_all("R1 secondary only");
        wr(2'd0, 32'h0000_0011, 1'b1);
        check_all("R1 both registers");
    endtask

    task automatic t_fields;
        logic [31:0] v;
        wr(2'd0, 32'hFFFF_FFFF, 1'b1);
        rd(2'd0, v);
        chk("R2 unused bits read zero", v, 32'h0003_FFFF);
        wr(2'd0, 32'h0000_0000, 1'b1);
        rd(2'd0, v);
        chk("R3 pad bits stay one", v & 32'h0000_FFC0, 32'h0000_FFC0);
        wr(2'd2, 32'h0003_FFFF, 1'b0);
        wr(2'd3, 32'h0003_FFFF, 1'b0);
        check_all("R2 other addresses write");
        rd(2'd2, v);
        chk("R2 other address reads zero", v, 32'h0);
    endtask

    task automatic t_lock_en;
        lock_en = 1'b0;
        wr(2'd0, flip_word(exp_pri), 1'b0);
        wr(2'd1, flip_word(exp_sec), 1'b0);
        check_all("R7 lock enable low");
        lock_en = 1'b1;
    endtask

    task automatic t_hv;
        hv_susp = 1'b1;
        wr(2'd0, flip_word(exp_pri), 1'b0);
        hv_susp = 1'b0;
        check_all("R6 suspended");
        wr(2'd0, flip_word(exp_pri), 1'b1);
        check_all("R6 resumed");
    endtask

    task automatic t_interlock;
        @(negedge clk); arr_wr = 1'b1;
        @(negedge clk); arr_wr = 1'b0;
        wr(2'd0, flip_word(exp_pri), 1'b0);
        check_all("R5 pending");
        @(negedge clk);
        op_done = 1'b1; reg_addr = 2'd1; reg_wdata = flip_word(exp_sec); reg_wr = 1'b1;
        @(negedge clk);
        op_done = 1'b0; reg_wr = 1'b0;
        check_all("R5 done cycle");
        wr(2'd1, flip_word(exp_sec), 1'b1);
        check_all("R5 after done");
        @(negedge clk);
        arr_wr = 1'b1; reg_addr = 2'd0; reg_wdata = flip_word(exp_pri); reg_wr = 1'b1;
        @(negedge clk);
        arr_wr = 1'b0; reg_wr = 1'b0;
        check_all("R5 same cycle as array write");
        @(negedge clk); arr_wr = 1'b1; op_done = 1'b1;
        @(negedge clk); arr_wr = 1'b0; op_done = 1'b0;
        wr(2'd0, flip_word(exp_pri), 1'b0);
        check_all("R5 array write wins over done");
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        wr(2'd0, flip_word(exp_pri), 1'b1);
        check_all("R5 cleared");
    endtask

    task automatic t_absent;
        do_reset(8'h00, 8'h00);
        chk("R9 absent locked with clear shadow", {24'b0, sect_lock}, {24'b0, ~PRES});
        lock_en = 1'b1;
        wr(2'd0, 32'h0, 1'b1);
        wr(2'd1, 32'h0, 1'b1);
        chk("R9 absent ignore writes", {24'b0, sect_lock}, 32'h0000_00A0);
        check_all("R9 absent readback");
    endtask

    task automatic t_erased;
        lock_en = 1'b0;
        do_reset(8'hFF, 8'hFF);
        chk("R8 erased shadow all locked", {24'b0, sect_lock}, 32'h0000_00FF);
        check_all("R8 erased readback");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_load();
        t_write_or();
        t_fields();
        t_lock_en();
        t_hv();
        t_interlock();
        t_absent();
        t_erased();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule